// File: doc/BRIEF.md
# Write-Only Two-Wire Control Register Slave

This block is a slave on a two-wire serial control bus (I2C) that only accepts writes. A controller sends a start condition, the device write byte, a subaddress byte and one or two data bytes, then a stop. The subaddress byte carries a two-bit chip field, which is compared with two strap pins, and a two-bit pointer that picks one of three control registers. The register contents drive parallel outputs: a sample-rate and serial-format setting, a stereo volume with a deemphasis enable, and a global configuration word. Nothing can be read back over the bus.

SCL and SDA are sampled on the system clock through a synchronizer. Start, stop and the two SCL edges are found in the sampled stream. A state machine walks the transfer through these states. `ST_IDLE` waits for a start. `ST_DEV` receives the device byte. `ST_SUB` receives the subaddress byte. `ST_DAT0` receives the first data byte and `ST_DAT1` receives the second byte of the volume register. `ST_SKIP` refuses any further bytes.

The state machine makes these transitions:
- A start moves any state to `ST_DEV`.
- A stop moves any state to `ST_IDLE`.
- A byte that is refused moves the machine to `ST_IDLE`.
- At the end of an acknowledge slot, `ST_DEV` moves to `ST_SUB` and `ST_SUB` moves to `ST_DAT0`.
- At the end of the acknowledge slot in `ST_DAT0`, the machine moves to `ST_DAT1` for the volume register and to `ST_SKIP` for the other two registers.
- At the end of the acknowledge slot in `ST_DAT1`, the machine moves to `ST_SKIP`.

Reset takes two steps. All registers are cleared while reset is held. On the first clock after release, the default values are loaded.

Top module: `wo_reg_i2c_slave`

## Requirements
- R1: While `rst_n` is low, every register output and `sda_pull` are 0. On the first clock after release the defaults load: rate register 0x00, volume 0x2C2C (both levels 0x2C, deemphasis off), configuration 0x04 (`dac_en`=1, every other bit 0).
- R2: The slave acknowledges only the device byte 0x9A, which is the 7-bit address 1001101 followed by a write bit of 0. Any other byte, including the read byte 0x9B, is not acknowledged. After a refused byte the slave ignores the bus until the next start.
- R3: Subaddress bits 7:6 must equal {`strap_hi`,`strap_lo`}. Subaddress bits 1:0 select the register: 01 = rate, 10 = volume, 11 = configuration. Bits 5:2 are ignored. A chip-field mismatch or pointer 00 is not acknowledged, and no register changes.
- R4: Up to four slaves share one bus, one for each strap value. With both straps at 1, only chip field 3 is accepted.
- R5: The volume register takes two data bytes. The first byte is bits 15:8 and the second is bits 7:0. Bit 14 is `deemph_en`, bits 13:8 are `vol_left` and bits 5:0 are `vol_right`. Level code 000000 is mute, 000001 is -75 dB, 101100 is 0 dB and 111000 is +18 dB.
- R6: The rate and configuration registers each take one data byte.
  - Rate register: bit 4 is `ws_swap`, bit 3 is `delay_bit` and bits 2:0 are `rate_code`.
  - Configuration register, bit 6 down to bit 0: `supply_hi`, `low_power`, `aux2_en`, `aux1_en`, `dac_en`, `aux_mono`, `invert_right`.
- R7: Reserved bits written as 1 are stored as 0. These are rate bits 7:5, volume bits 15 and 7:6, and configuration bit 7.
- R8: For each accepted byte, `sda_pull` is asserted from the SCL fall after the eighth bit until the SCL fall that ends the ninth clock. At all other times `sda_pull` stays 0.
- R9: A register changes only after its last data byte has been acknowledged. A volume write ended by a stop after its first byte leaves the volume register unchanged.
- R10: A data byte beyond the selected register's length is not acknowledged and changes nothing.
- R11: A repeated start abandons the transfer in progress and restarts at the device byte. A stop returns the slave to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| strap_hi | input | 1 | Chip-select strap, compared with subaddress bit 7 |
| strap_lo | input | 1 | Chip-select strap, compared with subaddress bit 6 |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| rate_code | output | 3 | Sample-rate range code |
| ws_swap | output | 1 | Word-select polarity swap |
| delay_bit | output | 1 | One-bit data delay after word-select change |
| deemph_en | output | 1 | Deemphasis enable |
| vol_left | output | 6 | Left volume level code |
| vol_right | output | 6 | Right volume level code |
| supply_hi | output | 1 | Higher-supply mode select |
| low_power | output | 1 | Low-power mode |
| aux2_en | output | 1 | Second auxiliary input enable |
| aux1_en | output | 1 | First auxiliary input enable |
| dac_en | output | 1 | Converter path enable |
| aux_mono | output | 1 | Auxiliary inputs mixed to mono |
| invert_right | output | 1 | Invert right output amplifier |

## Verification
The assertions rely on these properties of the inputs:
- Every SCL high or low phase lasts several system clocks longer than the synchronizer depth, so each edge is seen once and in order.
- SDA changes only while SCL is low, except to form a start or a stop.
- The straps do not change during a transfer.

The bench respects all three. It holds each bus phase for eight clocks and changes data only after it has driven SCL low. It changes the straps only between transfers. It models the wired-AND bus, so the slave's pull is visible on the data line.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_SUB,
        ST_DAT0,
        ST_DAT1,
        ST_SKIP
    } wr_state_t;

    localparam logic [7:0] DEV_WRITE_BYTE = 8'h9A;

    localparam logic [1:0] PTR_RATE = 2'b01;
    localparam logic [1:0] PTR_VOL  = 2'b10;
    localparam logic [1:0] PTR_CFG  = 2'b11;

    typedef struct packed {
        logic       ws_swap;
        logic       delay_bit;
        logic [2:0] rate_code;
    } rate_reg_t;

    typedef struct packed {
        logic       deemph;
        logic [5:0] left;
        logic [5:0] right;
    } vol_reg_t;

    typedef struct packed {
        logic supply_hi;
        logic low_power;
        logic aux2_en;
        logic aux1_en;
        logic dac_en;
        logic aux_mono;
        logic invert_right;
    } cfg_reg_t;

    localparam rate_reg_t DEF_RATE = '{ws_swap: 1'b0, delay_bit: 1'b0, rate_code: 3'd0};
    localparam vol_reg_t  DEF_VOL  = '{deemph: 1'b0, left: 6'h2C, right: 6'h2C};
    localparam cfg_reg_t  DEF_CFG  = '{supply_hi: 1'b0, low_power: 1'b0, aux2_en: 1'b0,
                                       aux1_en: 1'b0, dac_en: 1'b1, aux_mono: 1'b0,
                                       invert_right: 1'b0};

endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sh;
    logic [TOP:0] sda_sh;
    logic         scl_d;
    logic         sda_d;
    logic         scl_s;
    logic         sda_s;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[TOP-1:0], scl_in};
                    sda_sh <= {sda_sh[TOP-1:0], sda_in};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_in;
                    sda_sh <= sda_in;
                end
            end
        end
    endgenerate

    assign scl_s = scl_sh[TOP];
    assign sda_s = sda_sh[TOP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    assign sda_bit   = sda_s;

endmodule

// File: rtl/i2cw_byte_fsm.sv
module i2cw_byte_fsm
    import i2cw_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        start_det,
    input  logic        stop_det,
    input  logic        sda_bit,
    input  logic [1:0]  chip_sel,
    output logic        sda_pull,
    output logic        wr_en,
    output logic [1:0]  wr_ptr,
    output logic [15:0] wr_data
);

    localparam int CW = $clog2(BYTE_BITS + 2);
    localparam logic [CW-1:0] BYTE_END = CW'(BYTE_BITS);
    localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_BITS + 1);

    wr_state_t            state, nxt_state;
    logic [BYTE_BITS-1:0] shreg;
    logic [CW-1:0]        bit_cnt;
    logic [1:0]           ptr_q;
    logic [7:0]           hi_q;
    logic                 accept;
    logic                 byte_done;
    logic                 ack_end;

    assign byte_done = scl_fall && (bit_cnt == BYTE_END);
    assign ack_end   = scl_fall && (bit_cnt == ACK_SLOT);

    always_comb begin
        unique case (state)
            ST_DEV:           accept = (shreg == DEV_WRITE_BYTE);
            ST_SUB:           accept = (shreg[7:6] == chip_sel) && (shreg[1:0] != 2'b00);
            ST_DAT0, ST_DAT1: accept = 1'b1;
            default:          accept = 1'b0;
        endcase
    end

    always_comb begin
        nxt_state = state;
        if (start_det) begin
            nxt_state = ST_DEV;
        end else if (stop_det) begin
            nxt_state = ST_IDLE;
        end else if (byte_done && !accept) begin
            nxt_state = ST_IDLE;
        end else if (ack_end) begin
            unique case (state)
                ST_DEV:  nxt_state = ST_SUB;
                ST_SUB:  nxt_state = ST_DAT0;
                ST_DAT0: nxt_state = (ptr_q == PTR_VOL) ? ST_DAT1 : ST_SKIP;
                ST_DAT1: nxt_state = ST_SKIP;
                default: nxt_state = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
            ptr_q    <= 2'b00;
            hi_q     <= 8'h00;
            wr_en    <= 1'b0;
            wr_ptr   <= 2'b00;
            wr_data  <= 16'h0000;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise && bit_cnt < BYTE_END) begin
                    shreg   <= {shreg[BYTE_BITS-2:0], sda_bit};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (byte_done) begin
                    if (accept) begin
                        sda_pull <= 1'b1;
                        bit_cnt  <= ACK_SLOT;
                        if (state == ST_SUB)  ptr_q <= shreg[1:0];
                        if (state == ST_DAT0) hi_q  <= shreg;
                    end else begin
                        bit_cnt <= '0;
                    end
                end
                if (ack_end) begin
                    sda_pull <= 1'b0;
                    bit_cnt  <= '0;
                    if (state == ST_DAT0 && ptr_q != PTR_VOL) begin
                        wr_en   <= 1'b1;
                        wr_ptr  <= ptr_q;
                        wr_data <= {8'h00, shreg};
                    end
                    if (state == ST_DAT1) begin
                        wr_en   <= 1'b1;
                        wr_ptr  <= ptr_q;
                        wr_data <= {hi_q, shreg};
                    end
                end
            end
        end
    end

    a_r8_ack_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));
    a_r8_ack_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));
    a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);
    a_r11_start_to_dev: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV));
    a_r9_commit_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(scl_fall));

endmodule

// File: rtl/i2cw_reg_bank.sv
module i2cw_reg_bank
    import i2cw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_load,
    input  logic        wr_en,
    input  logic [1:0]  wr_ptr,
    input  logic [15:0] wr_data,
    output rate_reg_t   rate_r,
    output vol_reg_t    vol_r,
    output cfg_reg_t    cfg_r
);

    logic unused_rsvd;
    assign unused_rsvd = ^{wr_data[15], wr_data[7]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_r <= '0;
            vol_r  <= '0;
            cfg_r  <= '0;
        end else if (init_load) begin
            rate_r <= DEF_RATE;
            vol_r  <= DEF_VOL;
            cfg_r  <= DEF_CFG;
        end else if (wr_en) begin
            case (wr_ptr)
                PTR_RATE: rate_r <= rate_reg_t'(wr_data[4:0]);
                PTR_VOL:  vol_r  <= vol_reg_t'({wr_data[14:8], wr_data[5:0]});
                PTR_CFG:  cfg_r  <= cfg_reg_t'(wr_data[6:0]);
                default:  ;
            endcase
        end
    end

    a_r1_defaults_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (init_load && !wr_en) |=> (rate_r == DEF_RATE && vol_r == DEF_VOL && cfg_r == DEF_CFG));
    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_load && !wr_en) |=> ($stable(rate_r) && $stable(vol_r) && $stable(cfg_r)));

endmodule

// File: rtl/wo_reg_i2c_slave.sv
module wo_reg_i2c_slave
    import i2cw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       strap_hi,
    input  logic       strap_lo,
    output logic       sda_pull,
    output logic [2:0] rate_code,
    output logic       ws_swap,
    output logic       delay_bit,
    output logic       deemph_en,
    output logic [5:0] vol_left,
    output logic [5:0] vol_right,
    output logic       supply_hi,
    output logic       low_power,
    output logic       aux2_en,
    output logic       aux1_en,
    output logic       dac_en,
    output logic       aux_mono,
    output logic       invert_right
);

    logic        scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic        wr_en;
    logic [1:0]  wr_ptr;
    logic [15:0] wr_data;
    logic        init_pend;
    rate_reg_t   rate_r;
    vol_reg_t    vol_r;
    cfg_reg_t    cfg_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) init_pend <= 1'b1;
        else        init_pend <= 1'b0;
    end

    i2cw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .sda_bit(sda_bit)
    );

    i2cw_byte_fsm #(.BYTE_BITS(8)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
        .chip_sel({strap_hi, strap_lo}), .sda_pull(sda_pull),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data)
    );

    i2cw_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .init_load(init_pend), .wr_en(wr_en),
        .wr_ptr(wr_ptr), .wr_data(wr_data),
        .rate_r(rate_r), .vol_r(vol_r), .cfg_r(cfg_r)
    );

    assign rate_code    = rate_r.rate_code;
    assign ws_swap      = rate_r.ws_swap;
    assign delay_bit    = rate_r.delay_bit;
    assign deemph_en    = vol_r.deemph;
    assign vol_left     = vol_r.left;
    assign vol_right    = vol_r.right;
    assign supply_hi    = cfg_r.supply_hi;
    assign low_power    = cfg_r.low_power;
    assign aux2_en      = cfg_r.aux2_en;
    assign aux1_en      = cfg_r.aux1_en;
    assign dac_en       = cfg_r.dac_en;
    assign aux_mono     = cfg_r.aux_mono;
    assign invert_right = cfg_r.invert_right;

endmodule

// File: tb/wo_reg_i2c_slave_test.sv
`timescale 1ns/1ps
module wo_reg_i2c_slave_test;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] straps = 2'b00;
    logic       sda_pull;
    logic [2:0] rate_code;
    logic       ws_swap, delay_bit, deemph_en;
    logic [5:0] vol_left, vol_right;
    logic       supply_hi, low_power, aux2_en, aux1_en, dac_en, aux_mono, invert_right;
    logic       sda_bus;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    wo_reg_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .strap_hi(straps[1]), .strap_lo(straps[0]), .sda_pull(sda_pull),
        .rate_code(rate_code), .ws_swap(ws_swap), .delay_bit(delay_bit),
        .deemph_en(deemph_en), .vol_left(vol_left), .vol_right(vol_right),
        .supply_hi(supply_hi), .low_power(low_power), .aux2_en(aux2_en),
        .aux1_en(aux1_en), .dac_en(dac_en), .aux_mono(aux_mono),
        .invert_right(invert_right)
    );

    // Layout: straps[69:68] dev[67:60] sub[59:52] nbytes[51:50] d0[49:42] d1[41:34]
    //         ack_dev[33] ack_sub[32] rate[31:24] vol[23:8] cfg[7:0]
    localparam int NV = 12;
    localparam logic [69:0] VEC [NV] = '{
        {2'b00, 8'h9A, 8'h01, 2'd1, 8'h1B, 8'h00, 1'b1, 1'b1, 8'h1B, 16'h2C2C, 8'h04}, // R6 rate
        {2'b00, 8'h9A, 8'h02, 2'd2, 8'h45, 8'h30, 1'b1, 1'b1, 8'h1B, 16'h4530, 8'h04}, // R5 volume
        {2'b00, 8'h9A, 8'h03, 2'd1, 8'hFF, 8'h00, 1'b1, 1'b1, 8'h1B, 16'h4530, 8'h7F}, // R7 cfg rsvd
        {2'b10, 8'h9A, 8'h82, 2'd2, 8'hFF, 8'hFF, 1'b1, 1'b1, 8'h1B, 16'h7F3F, 8'h7F}, // R7 vol rsvd
        {2'b10, 8'h9A, 8'h43, 2'd1, 8'h00, 8'h00, 1'b1, 1'b0, 8'h1B, 16'h7F3F, 8'h7F}, // R3 mismatch
        {2'b11, 8'h9A, 8'hC1, 2'd1, 8'hE2, 8'h00, 1'b1, 1'b1, 8'h02, 16'h7F3F, 8'h7F}, // R4 chip 3
        {2'b11, 8'h9A, 8'h01, 2'd1, 8'h00, 8'h00, 1'b1, 1'b0, 8'h02, 16'h7F3F, 8'h7F}, // R4 chip 0 refused
        {2'b11, 8'h9B, 8'hC3, 2'd1, 8'h00, 8'h00, 1'b0, 1'b0, 8'h02, 16'h7F3F, 8'h7F}, // R2 read byte
        {2'b01, 8'h98, 8'h43, 2'd1, 8'h00, 8'h00, 1'b0, 1'b0, 8'h02, 16'h7F3F, 8'h7F}, // R2 wrong addr
        {2'b01, 8'h9A, 8'h40, 2'd1, 8'h00, 8'h00, 1'b1, 1'b0, 8'h02, 16'h7F3F, 8'h7F}, // R3 pointer 00
        {2'b01, 8'h9A, 8'h7E, 2'd2, 8'h2C, 8'h2C, 1'b1, 1'b1, 8'h02, 16'h2C2C, 8'h7F}, // R3 bits 5:2 ignored
        {2'b01, 8'h9A, 8'h43, 2'd1, 8'h00, 8'h00, 1'b1, 1'b1, 8'h02, 16'h2C2C, 8'h00}  // R6 cfg
    };

    function automatic logic [7:0] rd_rate();
        return {3'b000, ws_swap, delay_bit, rate_code};
    endfunction
    function automatic logic [15:0] rd_vol();
        return {1'b0, deemph_en, vol_left, 2'b00, vol_right};
    endfunction
    function automatic logic [7:0] rd_cfg();
        return {1'b0, supply_hi, low_power, aux2_en, aux1_en, dac_en, aux_mono, invert_right};
    endfunction

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitc(H);
        scl_m = 1'b1; waitc(H);
        sda_m = 1'b0; waitc(H);
        scl_m = 1'b0; waitc(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitc(H);
        scl_m = 1'b1; waitc(H);
        sda_m = 1'b1; waitc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitc(H);
            scl_m = 1'b1; waitc(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; waitc(H);
        scl_m = 1'b1; waitc(H / 2);
        ack = ~sda_bus;
        waitc(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic check_regs(input string tag, input logic [7:0] r,
                              input logic [15:0] v, input logic [7:0] c);
        chk({tag, " rate"}, {8'h00, rd_rate()}, {8'h00, r});
        chk({tag, " vol"},  rd_vol(), v);
        chk({tag, " cfg"},  {8'h00, rd_cfg()}, {8'h00, c});
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic a_dev, a_sub, a_x;
        waitc(3);
        // R1: all cleared while reset is held
        chk("R1 reset rate", {8'h00, rd_rate()}, 16'h0000);
        chk("R1 reset vol",  rd_vol(), 16'h0000);
        chk("R1 reset cfg",  {8'h00, rd_cfg()}, 16'h0000);
        chk("R1 reset pull", {15'd0, sda_pull}, 16'h0000);
        rst_n = 1'b1;
        waitc(2);
        check_regs("R1 defaults", 8'h00, 16'h2C2C, 8'h04);

        for (int k = 0; k < NV; k++) begin
            straps = VEC[k][69:68];
            waitc(H);
            bus_start();
            send_byte(VEC[k][67:60], a_dev);
            send_byte(VEC[k][59:52], a_sub);
            send_byte(VEC[k][49:42], a_x);
            if (VEC[k][51:50] == 2'd2) send_byte(VEC[k][41:34], a_x);
            bus_stop();
            waitc(H);
            chk($sformatf("R2 vec%0d dev ack", k), {15'd0, a_dev}, {15'd0, VEC[k][33]});
            chk($sformatf("R3 vec%0d sub ack", k), {15'd0, a_sub}, {15'd0, VEC[k][32]});
            check_regs($sformatf("R4 R5 R6 R7 vec%0d", k),
                       VEC[k][31:24], VEC[k][23:8], VEC[k][7:0]);
        end

        // R9: volume write cut short by stop after the first byte
        straps = 2'b00;
        waitc(H);
        bus_start();
        send_byte(8'h9A, a_dev);
        send_byte(8'h02, a_sub);
        send_byte(8'h11, a_x);
        chk("R8 first volume byte ack", {15'd0, a_x}, 16'h0001);
        bus_stop();
        waitc(H);
        chk("R9 truncated volume unchanged", rd_vol(), 16'h2C2C);
        chk("R8 pull released after stop", {15'd0, sda_pull}, 16'h0000);

        // R10: extra byte after an 8-bit register
        bus_start();
        send_byte(8'h9A, a_dev);
        send_byte(8'h03, a_sub);
        send_byte(8'hD5, a_x);
        send_byte(8'hAA, a_x);
        chk("R10 extra byte refused", {15'd0, a_x}, 16'h0000);
        bus_stop();
        waitc(H);
        chk("R10 cfg holds first byte", {8'h00, rd_cfg()}, 16'h0055);

        // R11: repeated start abandons the pending transfer
        bus_start();
        send_byte(8'h9A, a_dev);
        send_byte(8'h01, a_sub);
        bus_start();
        send_byte(8'h9A, a_dev);
        chk("R11 device ack after repeated start", {15'd0, a_dev}, 16'h0001);
        send_byte(8'h03, a_sub);
        send_byte(8'h12, a_x);
        bus_stop();
        waitc(H);
        chk("R11 rate untouched", {8'h00, rd_rate()}, 16'h0002);
        chk("R11 cfg written", {8'h00, rd_cfg()}, 16'h0012);

        // R1: reset again restores defaults
        rst_n = 1'b0;
        waitc(2);
        chk("R1 second reset vol clear", rd_vol(), 16'h0000);
        rst_n = 1'b1;
        waitc(2);
        check_regs("R1 defaults again", 8'h00, 16'h2C2C, 8'h04);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule